// File: doc/BRIEF.md
# DMA Instruction Sequencer

This block reads a DMA control program, one 32-bit word at a time, from a small instruction memory. It decodes each instruction, collects the argument words that follow it, and then carries it out. Write instructions become byte-write requests. Jumps reload the program counter. Write-control-register instructions with the immediate flag set become masked register writes. Flag bits on any instruction can raise interrupt pulses and advance a 16-bit completion counter.

The host places a program in memory, sets the start address and raises the run enable. A common program is a short "stopper" loop: a register write that raises interrupt 2, followed by a jump back to its own start address. The loop keeps running until software drops the run enable. Consumers read the completion counter and compare it against a tag using a wrap-tolerant signed difference.

Top module: `dma_seq_top`

## Requirements
- R1: While reset is held and afterwards until run is enabled, there are no memory reads and no requests or pulses, `halted` is low and `doneCount` is 0.
- R2: The opcode sits in bits 31:28. Valid codes are 0x1 write, 0x2 skip, 0x5 writec, 0x7 jump, 0x8 sync, 0x9 read, 0xA readc, 0xB writerm, 0xC writecm and 0xD writecr. An instruction occupies 2 words for write and jump, 3 for writerm and writecm, 4 for writecr, and 1 otherwise. Execution takes one fetch cycle, one decode cycle, one cycle per argument and one execute cycle.
- R3: A write produces a one-cycle request with these fields: address from word 2, count from bits 11:0, start-of-line from bit 27 and end-of-line from bit 26. No other opcode produces a request.
- R4: After a jump, the next instruction comes from the address held in word 2. After any other instruction, it comes from the address plus the instruction length.
- R5: A writecr with the immediate bit 12 set produces one register write: address from word 2, data equal to word 3 AND word 4, mask from word 4. A writecr without bit 12 produces no register write.
- R6: Bit 24 (irq1) and bit 25 (irq2) of an executed instruction each give a one-cycle pulse on the matching output.
- R7: An instruction with bit 16 or bit 17 set adds exactly one to `doneCount`. Bit 15 (resync) has no visible effect.
- R8: `tagReached` is high when (`doneCount` - `waitTag`), taken modulo 2^16 and read as a signed value, is zero or positive.
- R9: An invalid opcode gives one `opErrPulse`, applies none of its flags, and halts. While halted and enabled, no further reads occur. Dropping run leaves the halt.
- R10: Raising run from idle starts fetching at `startAddr`. Dropping run lets the current instruction finish and then returns to idle, which also ends a self-jump loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run enable; low stops at an instruction boundary |
| startAddr | input | ADDR_W | First instruction address |
| waitTag | input | CNT_W | Tag compared with the completion counter |
| memRdEn | output | 1 | Instruction memory read strobe |
| memAddr | output | ADDR_W | Instruction memory word address |
| memRdData | input | 32 | Read data, valid one cycle after the strobe |
| wrReqValid | output | 1 | Byte-write request strobe |
| wrReqAddr | output | 32 | Byte-write destination address |
| wrReqCount | output | 12 | Byte count |
| wrReqSol | output | 1 | Start-of-line flag |
| wrReqEol | output | 1 | End-of-line flag |
| regWrEn | output | 1 | Register write strobe |
| regWrAddr | output | 32 | Register address |
| regWrData | output | 32 | Masked value |
| regWrMask | output | 32 | Bit mask |
| irq1Pulse | output | 1 | Interrupt 1 pulse |
| irq2Pulse | output | 1 | Interrupt 2 pulse |
| opErrPulse | output | 1 | Invalid-opcode pulse |
| doneCount | output | CNT_W | Completion counter |
| tagReached | output | 1 | Wrap-tolerant counter comparison result |
| halted | output | 1 | Stopped on an invalid opcode |

## Verification
The assertions rely on read data being valid exactly one cycle after each read strobe. They also assume that `runEn` changes only between clock edges. The bench's memory model answers every strobe with a one-cycle latency, and all inputs are driven just after the falling edge. The halt and stop properties also assume that `runEn` is the only way out of a halt; the stimulus never uses reset for that while a program is running.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int WORD_W  = 32;
  localparam int COUNT_W = 12;

  localparam logic [3:0] OP_WRITE   = 4'h1;
  localparam logic [3:0] OP_SKIP    = 4'h2;
  localparam logic [3:0] OP_WRITEC  = 4'h5;
  localparam logic [3:0] OP_JUMP    = 4'h7;
  localparam logic [3:0] OP_SYNC    = 4'h8;
  localparam logic [3:0] OP_READ    = 4'h9;
  localparam logic [3:0] OP_READC   = 4'hA;
  localparam logic [3:0] OP_WRITERM = 4'hB;
  localparam logic [3:0] OP_WRITECM = 4'hC;
  localparam logic [3:0] OP_WRITECR = 4'hD;

  localparam int BIT_IMM  = 12;
  localparam int BIT_CNT0 = 16;
  localparam int BIT_CNT1 = 17;
  localparam int BIT_IRQ1 = 24;
  localparam int BIT_IRQ2 = 25;
  localparam int BIT_EOL  = 26;
  localparam int BIT_SOL  = 27;

  // Fields kept from the opcode word once it has been decoded.
  typedef struct packed {
    logic [3:0]         op;
    logic               bad;
    logic               imm;
    logic               countUp;
    logic               irq1;
    logic               irq2;
    logic               sol;
    logic               eol;
    logic [COUNT_W-1:0] count;
  } instrFields_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic       loadStart;
    logic       latchOp;
    logic       latchArg;
    logic [1:0] argSel;
    logic       rdEn;
    logic [1:0] rdOfs;
    logic       exec;
  } seqStrobe_t;

  function automatic logic opKnown(input logic [3:0] op);
    case (op)
      OP_WRITE, OP_SKIP, OP_WRITEC, OP_JUMP, OP_SYNC, OP_READ,
      OP_READC, OP_WRITERM, OP_WRITECM, OP_WRITECR: opKnown = 1'b1;
      default: opKnown = 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] wordsFor(input logic [3:0] op);
    case (op)
      OP_WRITE, OP_JUMP:       wordsFor = 3'd2;
      OP_WRITERM, OP_WRITECM:  wordsFor = 3'd3;
      OP_WRITECR:              wordsFor = 3'd4;
      default:                 wordsFor = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic [2:0] fetchLen,
  input  logic       fetchBad,
  output seqStrobe_t stb,
  output logic       halted
);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_ARG, S_EXEC, S_HALT
  } seqState_e;

  seqState_e  state, nextState;
  logic [1:0] argIdx;
  logic [2:0] lenHeld;
  logic       badHeld;
  logic       moreArgs;

  assign moreArgs = ((3'(argIdx) + 3'd1) < lenHeld);

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (runEn) begin
          stb.loadStart = 1'b1;
          nextState     = S_FETCH;
        end
      end
      S_FETCH: begin
        stb.rdEn  = 1'b1;
        stb.rdOfs = 2'd0;
        nextState = S_DECODE;
      end
      S_DECODE: begin
        stb.latchOp = 1'b1;
        if (fetchBad || fetchLen == 3'd1) begin
          nextState = S_EXEC;
        end else begin
          stb.rdEn  = 1'b1;
          stb.rdOfs = 2'd1;
          nextState = S_ARG;
        end
      end
      S_ARG: begin
        stb.latchArg = 1'b1;
        stb.argSel   = argIdx;
        if (moreArgs) begin
          stb.rdEn  = 1'b1;
          stb.rdOfs = argIdx + 2'd1;
        end else begin
          nextState = S_EXEC;
        end
      end
      S_EXEC: begin
        stb.exec = 1'b1;
        if (badHeld)    nextState = S_HALT;
        else if (runEn) nextState = S_FETCH;
        else            nextState = S_IDLE;
      end
      S_HALT: begin
        if (!runEn) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      argIdx  <= 2'd0;
      lenHeld <= 3'd1;
      badHeld <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_DECODE) begin
        lenHeld <= fetchBad ? 3'd1 : fetchLen;
        badHeld <= fetchBad;
        argIdx  <= 2'd1;
      end else if (state == S_ARG && moreArgs) begin
        argIdx <= argIdx + 2'd1;
      end
    end
  end

  assign halted = (state == S_HALT);

  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !runEn) |=> (state == S_IDLE)); // R10
  AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EXEC && !runEn && !badHeld) |=> (state == S_IDLE)); // R10
  AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HALT && runEn) |=> (state == S_HALT)); // R9
  AST_ARG_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ARG) |-> (3'(argIdx) < lenHeld)); // R2

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          stb,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [CNT_W-1:0]    waitTag,
  input  logic [WORD_W-1:0]   memRdData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [2:0]          fetchLen,
  output logic                fetchBad,
  output logic                wrReqValid,
  output logic [WORD_W-1:0]   wrReqAddr,
  output logic [COUNT_W-1:0]  wrReqCount,
  output logic                wrReqSol,
  output logic                wrReqEol,
  output logic                regWrEn,
  output logic [WORD_W-1:0]   regWrAddr,
  output logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   regWrMask,
  output logic                irq1Pulse,
  output logic                irq2Pulse,
  output logic                opErrPulse,
  output logic [CNT_W-1:0]    doneCount,
  output logic                tagReached
);

  localparam int ARG_N = 3;

  logic [ADDR_W-1:0]   pc;
  instrFields_t        cur;
  instrFields_t        fetched;
  logic [WORD_W-1:0]   argWord [1:ARG_N];
  logic                goodExec;
  logic [CNT_W-1:0]    tagDiff;

  // Decode of the word arriving from memory.
  assign fetchLen = wordsFor(memRdData[31:28]);
  assign fetchBad = !opKnown(memRdData[31:28]);

  always_comb begin
    fetched.op      = memRdData[31:28];
    fetched.bad     = fetchBad;
    fetched.imm     = memRdData[BIT_IMM];
    fetched.countUp = memRdData[BIT_CNT0] | memRdData[BIT_CNT1];
    fetched.irq1    = memRdData[BIT_IRQ1];
    fetched.irq2    = memRdData[BIT_IRQ2];
    fetched.sol     = memRdData[BIT_SOL];
    fetched.eol     = memRdData[BIT_EOL];
    fetched.count   = memRdData[COUNT_W-1:0];
  end

  assign memAddr = pc + ADDR_W'(stb.rdOfs);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= '0;
    end else if (stb.latchOp) begin
      cur <= fetched;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 1; i <= ARG_N; i++) argWord[i] <= '0;
    end else if (stb.latchArg) begin
      for (int i = 1; i <= ARG_N; i++)
        if (stb.argSel == 2'(i)) argWord[i] <= memRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0;
    end else if (stb.loadStart) begin
      pc <= startAddr;
    end else if (stb.exec) begin
      if (!cur.bad && cur.op == OP_JUMP) pc <= argWord[1][ADDR_W-1:0];
      else                               pc <= pc + ADDR_W'(wordsFor(cur.op));
    end
  end

  assign goodExec = stb.exec && !cur.bad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneCount <= '0;
    end else if (goodExec && cur.countUp) begin
      doneCount <= doneCount + CNT_W'(1);
    end
  end

  assign tagDiff    = doneCount - waitTag;
  assign tagReached = !tagDiff[CNT_W-1];

  assign wrReqValid = goodExec && cur.op == OP_WRITE;
  assign wrReqAddr  = argWord[1];
  assign wrReqCount = cur.count;
  assign wrReqSol   = cur.sol;
  assign wrReqEol   = cur.eol;

  assign regWrEn    = goodExec && cur.op == OP_WRITECR && cur.imm;
  assign regWrAddr  = argWord[1];
  assign regWrData  = argWord[2] & argWord[3];
  assign regWrMask  = argWord[3];

  assign irq1Pulse  = goodExec && cur.irq1;
  assign irq2Pulse  = goodExec && cur.irq2;
  assign opErrPulse = stb.exec && cur.bad;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (doneCount == $past(doneCount) || doneCount == $past(doneCount) + CNT_W'(1))); // R7
  AST_IRQ1_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq1Pulse |=> !irq1Pulse); // R6
  AST_IRQ2_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq2Pulse |=> !irq2Pulse); // R6
  AST_ERR_NO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    opErrPulse |=> $stable(doneCount)); // R9

endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [CNT_W-1:0]    waitTag,
  output logic                memRdEn,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic [31:0]         memRdData,
  output logic                wrReqValid,
  output logic [31:0]         wrReqAddr,
  output logic [11:0]         wrReqCount,
  output logic                wrReqSol,
  output logic                wrReqEol,
  output logic                regWrEn,
  output logic [31:0]         regWrAddr,
  output logic [31:0]         regWrData,
  output logic [31:0]         regWrMask,
  output logic                irq1Pulse,
  output logic                irq2Pulse,
  output logic                opErrPulse,
  output logic [CNT_W-1:0]    doneCount,
  output logic                tagReached,
  output logic                halted
);

  seqStrobe_t stb;
  logic [2:0] fetchLen;
  logic       fetchBad;

  seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .fetchLen (fetchLen),
    .fetchBad (fetchBad),
    .stb      (stb),
    .halted   (halted)
  );

  seq_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .startAddr  (startAddr),
    .waitTag    (waitTag),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .fetchLen   (fetchLen),
    .fetchBad   (fetchBad),
    .wrReqValid (wrReqValid),
    .wrReqAddr  (wrReqAddr),
    .wrReqCount (wrReqCount),
    .wrReqSol   (wrReqSol),
    .wrReqEol   (wrReqEol),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .regWrMask  (regWrMask),
    .irq1Pulse  (irq1Pulse),
    .irq2Pulse  (irq2Pulse),
    .opErrPulse (opErrPulse),
    .doneCount  (doneCount),
    .tagReached (tagReached)
  );

  assign memRdEn = stb.rdEn;

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    opErrPulse |=> halted); // R9
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    !(wrReqValid && regWrEn)); // R3
  AST_HALT_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memRdEn); // R9

endmodule

// File: tb/test_dma_seq_top.sv
`timescale 1ns/1ps
module test_dma_seq_top;

  localparam logic [31:0] SK = 32'h2000_0000;
  localparam int INV_AT = 12;

  typedef struct packed {
    logic [31:0] w0, a1, a2, a3;
    logic [7:0]  len, nxt;
    logic [3:0]  eWr, eReg, eI1, eI2, eCnt;
  } row_t;

  localparam int NROW = 13;
  localparam row_t ROWS [NROW] = '{
    '{32'h1C000040, 32'h00001000, SK, SK, 8'd2, 8'd2, 4'd1, 4'd0, 4'd0, 4'd0, 4'd0},
    '{32'h190007FF, 32'h00002004, SK, SK, 8'd2, 8'd2, 4'd1, 4'd0, 4'd1, 4'd0, 4'd0},
    '{32'h14000003, 32'h00003000, SK, SK, 8'd2, 8'd2, 4'd1, 4'd0, 4'd0, 4'd0, 4'd0},
    '{32'hD2001000, 32'h00000040, 32'hABCD1234, 32'h0000FFFF, 8'd4, 8'd4, 4'd0, 4'd1, 4'd0, 4'd1, 4'd0},
    '{32'hD0000000, 32'h00000044, 32'h00000055, 32'h00000066, 8'd4, 8'd4, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    '{32'h70000000, 32'h0000000A, SK, SK, 8'd2, 8'd10, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    '{32'h80018000, SK, SK, SK, 8'd1, 8'd1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1},
    '{32'hB1020000, 32'h10000000, 32'h10000000, SK, 8'd3, 8'd3, 4'd0, 4'd0, 4'd1, 4'd0, 4'd1},
    '{32'hC0000000, 32'h10000000, 32'h10000000, SK, 8'd3, 8'd3, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    '{32'h90000000, SK, SK, SK, 8'd1, 8'd1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    '{32'hA0000000, SK, SK, SK, 8'd1, 8'd1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    '{32'h50000000, SK, SK, SK, 8'd1, 8'd1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    '{32'h20030000, SK, SK, SK, 8'd1, 8'd1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [7:0]  startAddr = '0;
  logic [15:0] waitTag = '0;
  logic        memRdEn;
  logic [7:0]  memAddr;
  logic [31:0] memRdData = '0;
  logic        wrReqValid, wrReqSol, wrReqEol, regWrEn;
  logic [31:0] wrReqAddr, regWrAddr, regWrData, regWrMask;
  logic [11:0] wrReqCount;
  logic        irq1Pulse, irq2Pulse, opErrPulse, tagReached, halted;
  logic [15:0] doneCount;

  logic [31:0] mem [256];

  int nChk = 0, nFail = 0;
  int cyc = 0;
  int nWr = 0, nReg = 0, nI1 = 0, nI2 = 0, nErr = 0, nRd = 0, errAt = 0;
  logic [31:0] lastWrAddr, lastRegAddr, lastRegData, lastRegMask;
  logic [11:0] lastWrCount;
  logic        lastSol, lastEol;
  logic [15:0] expCnt = '0;

  always #4 clk = ~clk;

  dma_seq_top i_dma_seq_top (
    .clk(clk), .rstN(rstN), .runEn(runEn), .startAddr(startAddr), .waitTag(waitTag),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .wrReqValid(wrReqValid), .wrReqAddr(wrReqAddr), .wrReqCount(wrReqCount),
    .wrReqSol(wrReqSol), .wrReqEol(wrReqEol),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData), .regWrMask(regWrMask),
    .irq1Pulse(irq1Pulse), .irq2Pulse(irq2Pulse), .opErrPulse(opErrPulse),
    .doneCount(doneCount), .tagReached(tagReached), .halted(halted)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memRdEn) memRdData <= mem[memAddr];
  end

  always @(negedge clk) begin
    if (memRdEn) nRd++;
    if (wrReqValid) begin
      nWr++; lastWrAddr = wrReqAddr; lastWrCount = wrReqCount;
      lastSol = wrReqSol; lastEol = wrReqEol;
    end
    if (regWrEn) begin
      nReg++; lastRegAddr = regWrAddr; lastRegData = regWrData; lastRegMask = regWrMask;
    end
    if (irq1Pulse) nI1++;
    if (irq2Pulse) nI2++;
    if (opErrPulse) begin nErr++; errAt = cyc; end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic fillMem();
    for (int i = 0; i < 256; i++) mem[i] = SK;
  endtask

  task automatic runRow(input row_t rw);
    int bWr, bReg, bI1, bI2, bErr, bRd, s0, expAt;
    fillMem();
    mem[INV_AT] = 32'h0;
    mem[0] = rw.w0; mem[1] = rw.a1; mem[2] = rw.a2; mem[3] = rw.a3;
    bWr = nWr; bReg = nReg; bI1 = nI1; bI2 = nI2; bErr = nErr;
    startAddr = 8'd0;
    runEn = 1'b1;
    s0 = cyc;
    for (int k = 0; k < 80 && nErr == bErr; k++) stepN(1);
    expAt = (int'(rw.len) + 2) + (INV_AT - int'(rw.nxt)) * 3 + 3;
    chk(errAt - s0 == expAt, "R2 length/R4 next address (cycle of halt)", errAt - s0, expAt);
    chk(nWr - bWr == int'(rw.eWr), "R3 write request count", nWr - bWr, rw.eWr);
    if (rw.eWr != 0) begin
      chk(lastWrAddr == rw.a1, "R3 write address", lastWrAddr, rw.a1);
      chk(lastWrCount == rw.w0[11:0], "R3 write count", lastWrCount, rw.w0[11:0]);
      chk({lastSol, lastEol} == rw.w0[27:26], "R3 sol/eol", {lastSol, lastEol}, rw.w0[27:26]);
    end
    chk(nReg - bReg == int'(rw.eReg), "R5 register write count", nReg - bReg, rw.eReg);
    if (rw.eReg != 0) begin
      chk(lastRegAddr == rw.a1, "R5 register address", lastRegAddr, rw.a1);
      chk(lastRegData == (rw.a2 & rw.a3), "R5 masked value", lastRegData, rw.a2 & rw.a3);
      chk(lastRegMask == rw.a3, "R5 mask", lastRegMask, rw.a3);
    end
    chk(nI1 - bI1 == int'(rw.eI1), "R6 irq1 pulses", nI1 - bI1, rw.eI1);
    chk(nI2 - bI2 == int'(rw.eI2), "R6 irq2 pulses", nI2 - bI2, rw.eI2);
    expCnt = expCnt + 16'(rw.eCnt);
    chk(doneCount == expCnt, "R7 completion counter", doneCount, expCnt);
    bRd = nRd;
    stepN(6);
    chk(halted && nRd == bRd, "R9 halted without reads", {halted, 16'(nRd - bRd)}, 32'h10000);
    runEn = 1'b0;
    stepN(2);
    chk(!halted, "R9 halt left when run drops", halted, 0);
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    int bWr, bReg, bI1, bI2, bErr, bRd, s0;
    fillMem();
    stepN(4);
    chk(!memRdEn && !wrReqValid && !regWrEn && !irq1Pulse && !irq2Pulse && !opErrPulse && !halted,
        "R1 quiet during reset", {memRdEn, wrReqValid, regWrEn, halted}, 0);
    rstN = 1'b1;
    stepN(3);
    chk(nRd == 0 && doneCount == 0 && !halted, "R1 idle after reset", {16'(nRd), doneCount}, 0);

    // Vector table walk
    for (int r = 0; r < NROW; r++) runRow(ROWS[r]);

    // R10: start from a nonzero address
    fillMem();
    mem[21] = 32'h0;
    startAddr = 8'd20;
    bErr = nErr;
    runEn = 1'b1;
    s0 = cyc;
    for (int k = 0; k < 200 && nErr == bErr; k++) stepN(1);
    chk(errAt - s0 == 6, "R10 start at startAddr", errAt - s0, 6);
    runEn = 1'b0;
    stepN(2);

    // R9: invalid opcode carrying flags applies none of them
    fillMem();
    mem[0] = 32'hE3030000;
    startAddr = 8'd0;
    bI1 = nI1; bI2 = nI2; bErr = nErr;
    runEn = 1'b1;
    s0 = cyc;
    stepN(10);
    chk(nErr - bErr == 1 && errAt - s0 == 3, "R9 single error pulse at decode of word 0",
        errAt - s0, 3);
    chk(nI1 == bI1 && nI2 == bI2, "R9 no irq from invalid", 16'(nI1 - bI1 + nI2 - bI2), 0);
    chk(doneCount == expCnt, "R9 counter untouched", doneCount, expCnt);
    runEn = 1'b0;
    stepN(2);

    // Stopper loop: masked write with irq2, then a self-jump (R5, R6, R10)
    fillMem();
    mem[0] = 32'hD2001000; mem[1] = 32'h00000088; mem[2] = 32'h12345678; mem[3] = 32'h00FF00FF;
    mem[4] = 32'h70000000; mem[5] = 32'h00000000;
    bReg = nReg; bI2 = nI2;
    runEn = 1'b1;
    stepN(40);
    chk(nReg - bReg == 4, "R5 stopper writes in 40 cycles", nReg - bReg, 4);
    chk(nI2 - bI2 == 4, "R6 stopper irq2 pulses", nI2 - bI2, 4);
    chk(lastRegData == 32'h00340078 && lastRegAddr == 32'h88, "R5 stopper masked value",
        lastRegData, 32'h00340078);
    runEn = 1'b0;
    stepN(10);
    bRd = nRd; bReg = nReg;
    stepN(10);
    chk(nRd == bRd && nReg == bReg && !halted, "R10 self-loop left on run drop", nRd - bRd, 0);

    // R10: drop run during argument fetch; the instruction still completes
    bReg = nReg; bI2 = nI2; bRd = nRd; bWr = nWr;
    runEn = 1'b1;
    stepN(2);
    runEn = 1'b0;
    stepN(15);
    chk(nReg - bReg == 1 && nI2 - bI2 == 1, "R10 instruction completes after stop",
        nReg - bReg, 1);
    chk(nRd - bRd == 4 && nWr == bWr, "R10 no fetch beyond the boundary", nRd - bRd, 4);

    // R8: wrap-tolerant comparison
    waitTag = expCnt;                #1;
    chk(tagReached == 1'b1, "R8 equal tag", tagReached, 1);
    waitTag = expCnt + 16'd1;        #1;
    chk(tagReached == 1'b0, "R8 tag ahead", tagReached, 0);
    waitTag = expCnt - 16'h0010;     #1;
    chk(tagReached == 1'b1, "R8 tag behind across wrap", tagReached, 1);
    waitTag = expCnt + 16'h8000;     #1;
    chk(tagReached == 1'b0, "R8 half-range ahead", tagReached, 0);
    waitTag = expCnt + 16'h7FFF;     #1;
    chk(tagReached == 1'b0, "R8 far ahead", tagReached, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule